// File: doc/BRIEF.md
# Programmable-Tick Line Deglitcher

This block cleans an asynchronous single-wire bus input, such as a consumer-electronics control line, before a protocol engine samples it. The raw line first passes through a two-stage synchroniser. A chain of prescalers derived from the system clock produces a periodic tick, and the tick period is selected from four values, each a decade apart above the first. A change of the synchronised level reaches the filtered output only after the new level has held for a programmed number of ticks. A single-cycle strobe marks each accepted rising or falling edge.

The rejection window is three times the delay field times the selected tick period. The usual setting is the 1 µs tick with a delay of 7, which removes any pulse shorter than about 21 µs. A delay of zero turns filtering off: the synchronised level then goes straight to the output register. While the block is in soft reset or powered down, the output stays at the idle (high) bus level and the prescalers and stability counter are cleared.

Top module: `line_deglitch`

## Requirements
- R1: The raw line is sampled by two flops in series before filtering. With the delay set to 0, a raw level change shows on `line_filt` exactly three clock edges after it is applied.
- R2: The tick period in system clocks is BASE_DIV for `tick_sel`=0, BASE_DIV*US_DIV for 1, BASE_DIV*US_DIV*DEC_DIV for 2 and BASE_DIV*US_DIV*DEC_DIV² for 3. Counting starts at the first running cycle, and a tick falls on each running cycle k (counted from 0) where (k+1) is a multiple of the period.
- R3: With a delay d of 1 to 7, a synchronised level that differs from `line_filt` is taken on the tick that completes 3*d ticks counted while it has differed without a break.
- R4: When the synchronised level returns to the present output level, the count of ticks restarts from zero, so a shorter excursion never reaches the output.
- R5: With the delay set to 0, `line_filt` follows the synchronised level with no added delay and no dependence on the tick.
- R6: While `soft_rst` is 1, `line_filt` is 1, no strobe fires, and the tick count and prescalers are cleared.
- R7: The block runs only when `sys_clk_en` is 1 and `clk_mode` is 1 (gated) or 2 (free-running), and these two modes behave the same. `clk_mode` 0 (off) and the unused code 3 act like soft reset.
- R8: `rise_pulse` (or `fall_pulse`) is high for exactly the one cycle in which `line_filt` first shows an accepted 1 (or 0). Forcing the output high on entry to the idle state raises no strobe.
- R9: After `rst_n` is low at a clock edge, `line_filt` is 1 and both strobes are 0.
- R10: When the block leaves the idle state, the prescalers start again from zero, so the tick phase is fixed relative to that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_raw | input | 1 | Asynchronous bus line |
| tick_sel | input | 2 | Tick period select (0 to 3) |
| dly | input | 3 | Stability delay, in units of three ticks |
| soft_rst | input | 1 | Soft reset, active high |
| sys_clk_en | input | 1 | Enables the filter clock domain |
| clk_mode | input | 2 | 0 off, 1 gated, 2 free-running, 3 treated as off |
| line_filt | output | 1 | Filtered line level |
| rise_pulse | output | 1 | One-cycle strobe on an accepted rising edge |
| fall_pulse | output | 1 | One-cycle strobe on an accepted falling edge |

## Verification
The assertions check the following on every cycle: the output is high after any idle cycle, the two strobes are never high together, each strobe matches a real change of the output level, the stability count stays within its bound, the prescaler ticks are nested, and the zero-delay path tracks the synchroniser. Some behaviour can only be shown by the bench's scenarios, which compare the outputs with a behavioural reference on every clock. This covers the exact tick period for each select code, the cycle in which a held level is accepted, the rejection of glitches that come back just short of the threshold, and the fixed tick phase after leaving soft reset or power-down.

// File: rtl/dgl_pkg.sv
// Package: shared types and helpers for the line deglitcher.
// Assumes: prescaler stage divisors are all at least 1.
package dgl_pkg;

    // Clock-control field encoding.
    typedef enum logic [1:0] {
        CLK_OFF   = 2'd0,
        CLK_GATED = 2'd1,
        CLK_FREE  = 2'd2,
        CLK_RSVD  = 2'd3
    } clk_mode_e;

    localparam int NUM_TICKS = 4;

    // Divisor applied by prescaler stage g (base, micro, then two decades).
    function automatic int stage_div(input int g, input int b, input int u, input int d);
        case (g)
            0:       return b;
            1:       return u;
            default: return d;
        endcase
    endfunction

    // Largest stage divisor, used to size stage counters.
    function automatic int max_div(input int b, input int u, input int d);
        int m;
        m = b;
        if (u > m) m = u;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/dgl_sync.sv
// Module: multi-flop synchroniser for one asynchronous bit.
// Assumes: input is quasi-static relative to clk; reset value is the idle level.
module dgl_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/dgl_tick_gen.sv
// Module: cascaded prescaler producing four nested periodic ticks, one selected.
// Assumes: run low clears every stage so the tick phase restarts on enable.
module dgl_tick_gen
    import dgl_pkg::*;
#(
    parameter int BASE_DIV = 3,
    parameter int US_DIV   = 8,
    parameter int DEC_DIV  = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] tick_sel,
    output logic       tick
);

    localparam int MAXD = max_div(BASE_DIV, US_DIV, DEC_DIV);
    localparam int CW   = (MAXD > 1) ? $clog2(MAXD) : 1;

    logic [NUM_TICKS-1:0] stage_tick;

    for (genvar g = 0; g < NUM_TICKS; g++) begin : g_stage
        localparam int DIV = stage_div(g, BASE_DIV, US_DIV, DEC_DIV);
        logic [CW-1:0] cnt_q;
        logic          adv;

        if (g == 0) begin : g_first
            assign adv = run;
        end else begin : g_next
            assign adv = stage_tick[g-1];
        end

        assign stage_tick[g] = adv && (cnt_q == CW'(DIV - 1));

        // Count advance pulses from the previous stage, wrapping at DIV.
        always_ff @(posedge clk) begin
            if (!rst_n || !run)  cnt_q <= '0;
            else if (stage_tick[g]) cnt_q <= '0;
            else if (adv)        cnt_q <= cnt_q + 1'b1;
        end

        if (g > 0) begin : g_chk
            AST_TICK_NESTED: assert property (@(posedge clk) disable iff (!rst_n)
                stage_tick[g] |-> stage_tick[g-1]);                 // R2
        end
    end

    // Pick the requested tick period.
    always_comb begin
        tick = stage_tick[tick_sel];
    end

    AST_TICK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !(|stage_tick));                                   // R10

endmodule

// File: rtl/dgl_filter_core.sv
// Module: stability counter that accepts a new line level after 3*dly ticks.
// Assumes: sync_lvl is already synchronous; tick is a one-cycle pulse.
module dgl_filter_core #(
    parameter int DLY_W     = 3,
    parameter int TICK_MULT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             sync_lvl,
    input  logic             tick,
    input  logic [DLY_W-1:0] dly,
    output logic             filt,
    output logic             rise,
    output logic             fall
);

    localparam int THR_MAX = ((1 << DLY_W) - 1) * TICK_MULT;
    localparam int CNT_W   = $clog2(THR_MAX + 1);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] thr;
    logic             filt_q, filt_d;
    logic             rise_q, fall_q;

    assign thr = CNT_W'(dly) * CNT_W'(TICK_MULT);

    // Decide the next output level and the next tick count.
    always_comb begin
        filt_d = filt_q;
        cnt_d  = cnt_q;
        if (!run) begin
            filt_d = 1'b1;
            cnt_d  = '0;
        end else if (dly == '0) begin
            filt_d = sync_lvl;
            cnt_d  = '0;
        end else if (sync_lvl == filt_q) begin
            cnt_d  = '0;
        end else if (tick) begin
            if ((cnt_q + 1'b1) >= thr) begin
                filt_d = sync_lvl;
                cnt_d  = '0;
            end else begin
                cnt_d  = cnt_q + 1'b1;
            end
        end
    end

    // Register output level, count and edge strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_q <= 1'b1;
            cnt_q  <= '0;
            rise_q <= 1'b0;
            fall_q <= 1'b0;
        end else begin
            filt_q <= filt_d;
            cnt_q  <= cnt_d;
            rise_q <= run &&  filt_d && !filt_q;
            fall_q <= run && !filt_d &&  filt_q;
        end
    end

    assign filt = filt_q;
    assign rise = rise_q;
    assign fall = fall_q;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(THR_MAX));                                   // R4
    AST_DLY0_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (run && dly == '0) |=> (filt_q == $past(sync_lvl)));         // R5

endmodule

// File: rtl/line_deglitch.sv
// Module: top of the programmable-tick line deglitcher.
// Assumes: control inputs are synchronous to clk; line_raw is asynchronous.
module line_deglitch
    import dgl_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int BASE_DIV    = 3,
    parameter int US_DIV      = 8,
    parameter int DEC_DIV     = 10,
    parameter int DLY_W       = 3,
    parameter int TICK_MULT   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_raw,
    input  logic [1:0]       tick_sel,
    input  logic [DLY_W-1:0] dly,
    input  logic             soft_rst,
    input  logic             sys_clk_en,
    input  logic [1:0]       clk_mode,
    output logic             line_filt,
    output logic             rise_pulse,
    output logic             fall_pulse
);

    logic run;
    logic sync_lvl;
    logic tick;
    clk_mode_e mode;

    // Decode whether the filter domain is running.
    always_comb begin
        mode = clk_mode_e'(clk_mode);
        run  = !soft_rst && sys_clk_en && (mode == CLK_GATED || mode == CLK_FREE);
    end

    dgl_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (line_raw),
        .sync_out (sync_lvl)
    );

    dgl_tick_gen #(
        .BASE_DIV (BASE_DIV),
        .US_DIV   (US_DIV),
        .DEC_DIV  (DEC_DIV)
    ) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .tick_sel (tick_sel),
        .tick     (tick)
    );

    dgl_filter_core #(
        .DLY_W     (DLY_W),
        .TICK_MULT (TICK_MULT)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .sync_lvl (sync_lvl),
        .tick     (tick),
        .dly      (dly),
        .filt     (line_filt),
        .rise     (rise_pulse),
        .fall     (fall_pulse)
    );

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst || !sys_clk_en || clk_mode == 2'd0 || clk_mode == 2'd3) |=> line_filt); // R6
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_pulse && fall_pulse));                               // R8
    AST_RISE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_pulse |-> (line_filt && !$past(line_filt)));           // R8
    AST_FALL_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        fall_pulse |-> (!line_filt && $past(line_filt)));           // R8
    AST_FALL_STROBED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_filt) |-> fall_pulse);                           // R3

endmodule

// File: tb/line_deglitch_bench.sv
// Bench: behavioural reference model compared with the design on every clock.
module line_deglitch_bench;

    localparam int B = 3;
    localparam int U = 2;
    localparam int D = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_raw = 1'b1;
    logic [1:0] tick_sel = 2'd0;
    logic [2:0] dly = 3'd0;
    logic       soft_rst = 1'b0;
    logic       sys_clk_en = 1'b1;
    logic [1:0] clk_mode = 2'd1;
    logic       line_filt, rise_pulse, fall_pulse;

    int    vectors = 0;
    int    errors = 0;
    int    cycles = 0;
    bit    cmp_on = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R9";

    always #2 clk = ~clk;   // 250 MHz

    line_deglitch #(
        .BASE_DIV (B),
        .US_DIV   (U),
        .DEC_DIV  (D)
    ) u_line_deglitch (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_raw   (line_raw),
        .tick_sel   (tick_sel),
        .dly        (dly),
        .soft_rst   (soft_rst),
        .sys_clk_en (sys_clk_en),
        .clk_mode   (clk_mode),
        .line_filt  (line_filt),
        .rise_pulse (rise_pulse),
        .fall_pulse (fall_pulse)
    );

    // Reference model state.
    bit m_s1 = 1, m_s2 = 1, m_out = 1, m_rise = 0, m_fall = 0;
    int m_cnt = 0, m_phase = 0;

    function automatic int period(input int sel);
        case (sel)
            0:       return B;
            1:       return B * U;
            2:       return B * U * D;
            default: return B * U * D * D;
        endcase
    endfunction

    always @(posedge clk) begin
        bit run, tk, nout;
        int ncnt, per;
        if (!rst_n) begin
            m_s1 = 1; m_s2 = 1; m_out = 1; m_cnt = 0; m_phase = 0;
            m_rise = 0; m_fall = 0;
        end else begin
            run  = !soft_rst && sys_clk_en && (clk_mode == 2'd1 || clk_mode == 2'd2);
            per  = period(int'(tick_sel));
            tk   = run && ((m_phase % per) == per - 1);
            nout = m_out;
            ncnt = m_cnt;
            if (!run) begin
                nout = 1; ncnt = 0;
            end else if (dly == 0) begin
                nout = m_s2; ncnt = 0;
            end else if (m_s2 == m_out) begin
                ncnt = 0;
            end else if (tk) begin
                if (m_cnt + 1 >= 3 * int'(dly)) begin
                    nout = m_s2; ncnt = 0;
                end else begin
                    ncnt = m_cnt + 1;
                end
            end
            m_rise  = run && nout && !m_out;
            m_fall  = run && !nout && m_out;
            m_out   = nout;
            m_cnt   = ncnt;
            m_phase = run ? m_phase + 1 : 0;
            m_s2    = m_s1;
            m_s1    = line_raw;
        end
    end

    // Compare outputs with the model away from the active edge.
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            vectors++;
            if (line_filt !== m_out || rise_pulse !== m_rise || fall_pulse !== m_fall) begin
                errors++;
                $display("FAIL %s: filt/rise/fall actual %b%b%b expected %b%b%b at cycle %0d",
                         cur_req, line_filt, rise_pulse, fall_pulse,
                         m_out, m_rise, m_fall, cycles);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    task automatic hold(input bit v, input int n);
        line_raw = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic pulses(input int n, input int minw, input int maxw);
        for (int i = 0; i < n; i++) begin
            hold(~line_raw, $urandom_range(maxw, minw));
        end
    endtask

    task automatic cfg(input int sel, input int d);
        tick_sel = 2'(sel);
        dly      = 3'(d);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cmp_on  = 1'b1;                 // R9: reset state compared here
        cur_req = "R9";
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R5: delay 0 follows raw three edges later
        cur_req = "R1";
        cfg(0, 0);
        hold(0, 6); hold(1, 1); hold(0, 2); hold(1, 5);
        cur_req = "R5";
        pulses(40, 1, 4);
        hold(1, 8);

        // R3: acceptance after 3*d ticks, base tick
        cur_req = "R3";
        cfg(0, 1);
        pulses(30, 2, 20);
        hold(1, 30);
        cfg(0, 3);
        pulses(20, 20, 40);
        hold(1, 40);

        // R4: glitches just short of the threshold restart the count
        cur_req = "R4";
        cfg(0, 2);
        for (int i = 0; i < 8; i++) begin
            hold(0, 15); hold(1, 1);
        end
        hold(0, 30);
        for (int i = 0; i < 8; i++) begin
            hold(1, 14); hold(0, 2);
        end
        hold(1, 30);

        // R2: each tick select
        cur_req = "R2";
        for (int s = 1; s < 4; s++) begin
            cfg(s, 1);
            pulses(8, period(s) * 2, period(s) * 4);
            hold(1, period(s) * 4);
        end
        cfg(2, 2);
        pulses(6, period(2) * 5, period(2) * 8);
        hold(1, period(2) * 8);

        // R6: soft reset forces idle high and clears the count
        cur_req = "R6";
        cfg(0, 2);
        hold(0, 30);
        soft_rst = 1'b1;
        hold(0, 6);
        soft_rst = 1'b0;
        hold(0, 25);
        hold(1, 30);

        // R7: power-down codes and both running modes
        cur_req = "R7";
        clk_mode = 2'd0; hold(0, 15); clk_mode = 2'd1; hold(0, 25); hold(1, 25);
        clk_mode = 2'd3; hold(0, 15); clk_mode = 2'd1; hold(0, 25); hold(1, 25);
        sys_clk_en = 1'b0; hold(0, 15); sys_clk_en = 1'b1; hold(0, 25); hold(1, 25);
        clk_mode = 2'd2;
        pulses(20, 5, 25);
        hold(1, 30);
        clk_mode = 2'd1;

        // R10: re-enable mid-pattern fixes the tick phase
        cur_req = "R10";
        cfg(1, 1);
        for (int i = 0; i < 6; i++) begin
            hold(0, 7 + i);
            soft_rst = 1'b1; hold(0, 1 + i); soft_rst = 1'b0;
            hold(0, 25); hold(1, 25);
        end

        // R8: strobes on a nominal setting with random traffic
        cur_req = "R8";
        cfg(1, 7);
        pulses(10, 100, 160);
        hold(1, 160);
        cfg(0, 1);
        pulses(60, 1, 14);
        hold(1, 20);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule